// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage register that either captures a parallel word or shifts serial data toward its last stage. Software never reaches it. Upstream logic drives two slow control lines, a clock line and an inhibit line. These two lines are merged into one combined clock. Each rising edge of the combined clock makes the register perform one step: a parallel capture or a one-place shift. The mode select chooses which.

The design does not form a real gated clock. Both control lines are brought into the fast system clock domain through synchronizers. The block ORs the synchronized lines and detects the rising edge of the result. That edge becomes a one-cycle update enable for the stage flops. A high level on either line blocks stepping. While one line rests low, the other line acts as the clock.

An active-low clear empties every stage at once. Its release is synchronized, so stepping resumes only a fixed number of system cycles later. The last stage is the serial output. All stages are also brought out so the parallel contents can be observed.

Top module: `gated_pload_shreg`

## Requirements
- R1: While `clr_n` is low, every stage reads zero at once, without waiting for a system clock edge, whatever the other inputs do.
- R2: After `clr_n` returns high, the stages stay zero through the next two system clock edges. The third system edge after release is the first one that can change them.
- R3: The combined clock is `ext_clk | ext_inh`. If a rising transition of it is first sampled at system edge k, the stages take their new value at system edge k+2.
- R4: While `ext_inh` is held high, toggling `ext_clk` leaves every stage unchanged.
- R5: While `ext_clk` is held low, a rising transition on `ext_inh` steps the register exactly as an `ext_clk` rise would.
- R6: With `mode_shift` = 1, a step moves `ser_in` into stage 0 and moves stage i into stage i+1. So `q_last` (stage 7) receives the old stage 6.
- R7: With `mode_shift` = 0, a step loads `par_in[i]` into stage i for every i, and `ser_in` has no effect on the result.
- R8: After a load, each further shift brings the next lower input to `q_last`. The order is `par_in[7]` first, then `par_in[6]`, and so on down to `par_in[0]`.
- R9: Without a combined-clock rise, the stages hold their value even while `mode_shift`, `ser_in` and `par_in` change.
- R10: A combined clock that stays high for many system cycles produces exactly one step.
- R11: `rst` high at a system clock edge zeroes the stages and the edge-detection state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of all stages |
| ext_clk | input | 1 | Slow step clock line |
| ext_inh | input | 1 | Step inhibit line, ORed with ext_clk |
| mode_shift | input | 1 | 1 = shift, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | W | Parallel data, bit i goes to stage i |
| stages | output | W | Current contents of all stages, bit 0 = first stage |
| q_last | output | 1 | Serial output, the last stage |

## Verification
The assertions check several properties on every cycle. The clear holds the stages at zero. Each update pulse lasts exactly one cycle. The clear is released only after two sampled high levels of `clr_n`. Every update produces either the loaded word or the shifted word, as the mode selects. A held inhibit freezes the stages. The bench's scenarios are needed for the effects that span many cycles. These include the output order after a load, the single step for a long clock-high period, the inhibit line standing in as the clock, and the edge being swallowed during the clear release window.

// File: rtl/gated_pload_shreg_pkg.sv
package gated_pload_shreg_pkg;

    // Operation applied to the stage array on a given system cycle.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } step_op_e;

    localparam int MIN_SYNC_DEPTH = 2;

    // Pick the step operation from the update pulse and the mode select.
    function automatic step_op_e pick_op(input logic pulse, input logic shift_sel);
        if (!pulse) begin
            return OP_HOLD;
        end
        return shift_sel ? OP_SHIFT : OP_LOAD;
    endfunction

endpackage

// File: rtl/gps_step_detect.sv
module gps_step_detect
    import gated_pload_shreg_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic ext_inh,
    output logic upd_pulse
);
    localparam int TOP = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0] clk_sync;
    logic [SYNC_DEPTH-1:0] inh_sync;
    logic                  comb_now;
    logic                  comb_prev;

    // Bring both slow lines into the system domain.
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sync <= '0;
            inh_sync <= '0;
        end else begin
            clk_sync <= {clk_sync[TOP-1:0], ext_clk};
            inh_sync <= {inh_sync[TOP-1:0], ext_inh};
        end
    end

    // Combined clock: a high level on either line keeps it high.
    assign comb_now = clk_sync[TOP] | inh_sync[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_prev <= 1'b0;
        end else begin
            comb_prev <= comb_now;
        end
    end

    assign upd_pulse = comb_now & ~comb_prev;

    if (SYNC_DEPTH < MIN_SYNC_DEPTH) begin : g_bad_depth
        initial $error("SYNC_DEPTH must be at least %0d", MIN_SYNC_DEPTH);
    end

endmodule

// File: rtl/gps_clear_sync.sv
module gps_clear_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic clr_ok
);
    localparam int TOP = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0] rel_pipe;

    // Assertion is immediate; release ripples through the pipe.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            rel_pipe <= '0;
        end else begin
            rel_pipe <= {rel_pipe[TOP-1:0], 1'b1};
        end
    end

    assign clr_ok = rel_pipe[TOP];

endmodule

// File: rtl/gps_stage_array.sv
module gps_stage_array
    import gated_pload_shreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_ok,
    input  logic         upd_pulse,
    input  logic         mode_shift,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] stages
);
    step_op_e     op;
    logic [W-1:0] shift_src;
    logic [W-1:0] next_val;

    assign op = pick_op(upd_pulse, mode_shift);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_head
            assign shift_src[i] = ser_in;
        end else begin : g_tail
            assign shift_src[i] = stages[i-1];
        end
        assign next_val[i] = (op == OP_LOAD) ? par_in[i] : shift_src[i];
    end

    always_ff @(posedge clk or negedge clr_ok) begin
        if (!clr_ok) begin
            stages <= '0;
        end else if (rst) begin
            stages <= '0;
        end else if (op != OP_HOLD) begin
            stages <= next_val;
        end
    end

endmodule

// File: rtl/gated_pload_shreg.sv
module gated_pload_shreg #(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         ext_clk,
    input  logic         ext_inh,
    input  logic         mode_shift,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] stages,
    output logic         q_last
);
    logic upd_pulse;
    logic clr_ok;

    gps_step_detect #(.SYNC_DEPTH(SYNC_DEPTH)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .ext_clk   (ext_clk),
        .ext_inh   (ext_inh),
        .upd_pulse (upd_pulse)
    );

    gps_clear_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_clear (
        .clk    (clk),
        .clr_n  (clr_n),
        .clr_ok (clr_ok)
    );

    gps_stage_array #(.W(W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .clr_ok     (clr_ok),
        .upd_pulse  (upd_pulse),
        .mode_shift (mode_shift),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .stages     (stages)
    );

    assign q_last = stages[W-1];

endmodule

// File: rtl/gated_pload_shreg_chk.sv
module gated_pload_shreg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_n,
    input logic         ext_inh,
    input logic         mode_shift,
    input logic         ser_in,
    input logic [W-1:0] par_in,
    input logic [W-1:0] stages,
    input logic         upd_pulse,
    input logic         clr_ok
);
    // R1: a low clear input always shows empty stages.
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> stages == '0);

    // R2: release needs two sampled high levels of the clear input.
    a_r2_release_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_ok) |-> ($past(clr_n) && $past(clr_n, 2)));

    // R10: an update pulse never lasts more than one cycle.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse);

    // R6: a shift step moves every stage up by one place.
    a_r6_shift_step: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (upd_pulse && clr_ok && mode_shift) |=>
            stages == {$past(stages[W-2:0]), $past(ser_in)});

    // R7: a load step captures the parallel word.
    a_r7_load_step: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (upd_pulse && clr_ok && !mode_shift) |=> stages == $past(par_in));

    // R4: a long-held inhibit freezes the stages.
    a_r4_inhibit_freeze: assert property (@(posedge clk) disable iff (rst)
        (clr_n && $past(clr_n) && !$past(rst) && $past(ext_inh) && $past(ext_inh, 2)
         && $past(ext_inh, 3) && $past(ext_inh, 4)) |-> $stable(stages));

endmodule

bind gated_pload_shreg gated_pload_shreg_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_n      (clr_n),
    .ext_inh    (ext_inh),
    .mode_shift (mode_shift),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .stages     (stages),
    .upd_pulse  (upd_pulse),
    .clr_ok     (clr_ok)
);

// File: tb/tb_gated_pload_shreg.sv
module tb_gated_pload_shreg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_n = 1'b1;
    logic         ext_clk = 1'b0;
    logic         ext_inh = 1'b0;
    logic         mode_shift = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] stages;
    logic         q_last;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    bit  cmp_on  = 0;

    always #5 clk = ~clk;

    gated_pload_shreg #(.W(W)) dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .ext_clk(ext_clk), .ext_inh(ext_inh),
        .mode_shift(mode_shift), .ser_in(ser_in), .par_in(par_in),
        .stages(stages), .q_last(q_last)
    );

    // Behavioural reference: history of sampled combined clock, release count.
    logic [W-1:0] m_st;
    int           rel_cnt;
    bit           hist[$];
    bit           act;

    initial begin
        m_st    = '0;
        rel_cnt = 2;
        hist    = '{0, 0, 0};
    end

    always @(posedge clk) begin
        act = hist[1] && !hist[2];
        if (!clr_n) begin
            m_st    = '0;
            rel_cnt = 0;
        end else begin
            if (rst) begin
                m_st = '0;
            end else if (rel_cnt >= 2 && act) begin
                if (mode_shift) m_st = {m_st[W-2:0], ser_in};
                else            m_st = par_in;
            end
            if (rel_cnt < 2) rel_cnt++;
        end
        if (rst) begin
            hist = '{0, 0, 0};
        end else begin
            hist.push_front(ext_clk | ext_inh);
            void'(hist.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input logic [W-1:0] act_v,
                         input logic [W-1:0] exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // Per-cycle comparison against the reference (R3 timing, R6, R7, R9).
    always @(posedge clk) begin
        #2;
        if (cmp_on) check(stages == m_st, "R3 cycle model", stages, m_st);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_clk();
        @(negedge clk) ext_clk = 1'b1;
        cyc(4);
        ext_clk = 1'b0;
        cyc(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] snap;
        logic [W-1:0] word;
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R11: reset state
        check(stages == '0 && q_last == 1'b0, "R11 reset state", stages, '0);
        cmp_on = 1;

        // R7: parallel load, serial input ignored
        mode_shift = 1'b0; ser_in = 1'b1; par_in = 8'hA5;
        step_clk();
        check(stages == 8'hA5, "R7 load ignores ser_in", stages, 8'hA5);

        // R6: shifts with varied serial bits
        mode_shift = 1'b1;
        snap = stages;
        ser_in = 1'b0; step_clk();
        check(stages == {snap[6:0], 1'b0}, "R6 shift zero in", stages, {snap[6:0], 1'b0});
        snap = stages;
        ser_in = 1'b1; step_clk();
        check(stages == {snap[6:0], 1'b1}, "R6 shift one in", stages, {snap[6:0], 1'b1});

        // R8: load then read out on q_last, highest input first
        word = 8'b1011_0010;
        mode_shift = 1'b0; par_in = word;
        step_clk();
        mode_shift = 1'b1; ser_in = 1'b0;
        for (int j = 7; j >= 0; j--) begin
            check(q_last == word[j], "R8 serial order", {7'd0, q_last}, {7'd0, word[j]});
            if (j > 0) step_clk();
        end

        // R4: inhibit raised while ext_clk high, then ext_clk toggled
        @(negedge clk) ext_clk = 1'b1;
        cyc(4);
        snap = stages;
        ext_inh = 1'b1;
        cyc(2);
        for (int k = 0; k < 3; k++) begin
            ext_clk = 1'b0; cyc(4);
            ext_clk = 1'b1; cyc(4);
        end
        check(stages == snap, "R4 inhibit blocks steps", stages, snap);
        ext_inh = 1'b0;
        cyc(4);
        check(stages == snap, "R4 inhibit drop while clk high", stages, snap);
        ext_clk = 1'b0;
        cyc(4);

        // R5: inhibit line acting as the clock
        snap = stages; ser_in = 1'b1; mode_shift = 1'b1;
        ext_inh = 1'b1; cyc(4);
        ext_inh = 1'b0; cyc(4);
        check(stages == {snap[6:0], 1'b1}, "R5 inhibit used as clock", stages, {snap[6:0], 1'b1});

        // R10: long clock-high period gives one step
        snap = stages; ser_in = 1'b0;
        ext_clk = 1'b1; cyc(20);
        check(stages == {snap[6:0], 1'b0}, "R10 single step", stages, {snap[6:0], 1'b0});
        ext_clk = 1'b0; cyc(4);

        // R9: data and mode changes without an edge
        snap = stages;
        for (int k = 0; k < 6; k++) begin
            mode_shift = k[0]; ser_in = ~ser_in; par_in = par_in ^ 8'h3C;
            cyc(1);
        end
        cyc(3);
        check(stages == snap, "R9 hold without edge", stages, snap);

        // R1: asynchronous clear with non-zero contents and ext_clk high
        mode_shift = 1'b0; par_in = 8'hFF; step_clk();
        ext_clk = 1'b1;
        cyc(1);
        #1 clr_n = 1'b0;
        #1 check(stages == '0, "R1 clear immediate", stages, '0);
        ext_clk = 1'b0;
        cyc(4);
        check(stages == '0, "R1 clear held", stages, '0);

        // R2: an edge landing inside the release window is lost
        par_in = 8'h5A; mode_shift = 1'b0;
        ext_clk = 1'b1;
        cyc(1);
        clr_n = 1'b1;
        cyc(6);
        check(stages == '0, "R2 edge swallowed in release", stages, '0);
        ext_clk = 1'b0; cyc(4);
        step_clk();
        check(stages == 8'h5A, "R2 stepping after release", stages, 8'h5A);

        // R11: synchronous reset mid-run
        rst = 1'b1; cyc(1);
        rst = 1'b0; #2;
        check(stages == '0, "R11 reset mid-run", stages, '0);
        cyc(4);
        finish_run();
    end

endmodule